// File: doc/BRIEF.md
# Multi-Phase Built-In-Test Sine Generator

This block produces low-frequency digital sine samples used as a built-in-test stimulus. The samples are fed into analog signal chains, and the values that come back are later compared against the values that were commanded. The generator keeps a single phase accumulator that advances by a programmable tuning word on each internal sample tick. From that one phase it builds four outputs: a reference wave, a quadrature copy that leads the reference by 90°, and two copies offset by 120° and 240°. Together with the reference, the last two form a balanced three-phase set.

All four outputs are read from one quarter-wave magnitude table. The full wave is rebuilt by mirroring the table index and flipping the sign according to the quadrant. Each magnitude is scaled by an amplitude input and rounded to a signed 16-bit sample. The generator is synchronous with the sampling system. Because the phase index travels with every sample, a downstream checker knows exactly which value was commanded at each sample instant. The tuning word is expected to keep the stimulus just above DC, well below the sensor bands.

Top module: `bist_sine_gen`

## Requirements
- R1: A synchronous reset clears the phase to zero. While `rst` is high, all four samples, `phaseIdx` and `sampleValid` are zero. The first strobe after reset reports `phaseIdx` = 0.
- R2: While `enable` is high, `sampleValid` pulses high for exactly one cycle every SAMPLE_DIV clock cycles (default 4). The first pulse comes SAMPLE_DIV cycles after `enable` is sampled high.
- R3: At strobe n since the last reset, `phaseIdx` equals bits 23..14 of the accumulated phase P(n). P(0) = 0, and P(n+1) = (P(n) + tuningWord) mod 2^24. The phase advances only on strobes.
- R4: `sample0` = floor((S(j)·A + 32768) / 65536), within ±1 LSB. Here A is `ampScale` read as an unsigned value, j = `phaseIdx`, and S(j) = round(32767·sin((2j+1)·π/1024)). S is negative for j in 512..1023.
- R5: `sample90` follows the same rule with j = (`phaseIdx` + 256) mod 1024. This makes it the cosine of the reference.
- R6: `sample120` uses j = (`phaseIdx` + 341) mod 1024, and `sample240` uses j = (`phaseIdx` + 683) mod 1024.
- R7: Amplitude scaling is linear and rounded. With A = 0 every sample is exactly 0. For any A, the magnitude of every sample is at most floor(A/2) + 1.
- R8: One cycle after `enable` is low, all samples are zero and `sampleValid` stays low. The phase is held, so re-enabling continues from the phase where the output stopped.
- R9: Between strobes, while enabled, the samples and `phaseIdx` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; low forces zero outputs and freezes the phase |
| tuningWord | input | 24 | Phase increment per sample tick |
| ampScale | input | 16 | Unsigned amplitude scale, 0xFFFF close to full scale |
| sample0 | output | 16 | Signed reference sample |
| sample90 | output | 16 | Signed sample leading by 90° |
| sample120 | output | 16 | Signed sample offset by 120° |
| sample240 | output | 16 | Signed sample offset by 240° |
| sampleValid | output | 1 | One-cycle strobe marking new samples |
| phaseIdx | output | 10 | Table index of the reference at this strobe |

## Verification
The hardest thing to reach from the ports is every quadrant-boundary index of the mirrored table for all four offsets at once. This is made harder because the 120° and 240° offsets are not a whole quarter. The stimulus sets the tuning word to one index step per strobe, so 1024 consecutive strobes walk every table index through every output, including the wrap back to index 0. The second hardest case is the phase freeze: `enable` is dropped partway through a run, and continuity is proven by the `phaseIdx` and samples of the first strobe after re-enable. Expected samples come from real-valued sine arithmetic in the bench.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;   // advance phase and load new samples
    logic clear;  // force outputs to zero, freeze phase
  } bsgCtrl_t;

  localparam longint PI_Q30 = 64'sd3373259426;

  // Quarter-wave magnitude at half-step points, via fixed-point Taylor series
  function automatic int quarterSine(int k, int qDepth, int peak);
    longint x, x2, term, sum;
    x    = (longint'(2 * k + 1) * PI_Q30) / longint'(4 * qDepth);
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int n = 1; n <= 7; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return int'((sum * longint'(peak) + (64'sd1 <<< 29)) >>> 30);
  endfunction

  // Index offset per output: 0, quarter, third, two thirds (rounded)
  function automatic int phaseOffset(int p, int idxW);
    int n;
    n = 1 << idxW;
    case (p)
      1:       return n / 4;
      2:       return (n + 1) / 3;
      3:       return (2 * n + 1) / 3;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/bsg_lookup.sv
module bsg_lookup #(
  parameter int IDX_W = 10,
  parameter int MAG_W = 15
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [MAG_W:0]   value
);
  localparam int QW     = IDX_W - 2;
  localparam int QDEPTH = 1 << QW;
  localparam int PEAK   = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] quarter [QDEPTH];

  for (genvar g = 0; g < QDEPTH; g++) begin : gTab
    localparam int V = bsg_pkg::quarterSine(g, QDEPTH, PEAK);
    assign quarter[g] = MAG_W'(V);
  end

  logic [QW-1:0]    addr;
  logic [MAG_W-1:0] mag;

  always_comb begin
    addr  = idx[IDX_W-2] ? ~idx[QW-1:0] : idx[QW-1:0];
    mag   = quarter[addr];
    value = idx[IDX_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/bsg_ctrl.sv
module bsg_ctrl #(
  parameter int SAMPLE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  output bsg_pkg::bsgCtrl_t ctrl
);
  localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_DIV - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      divCnt <= '0;
    end else if (divCnt == LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.tick  = enable && (divCnt == LAST);
    ctrl.clear = !enable;
  end
endmodule

// File: rtl/bsg_datapath.sv
module bsg_datapath #(
  parameter int ACC_W = 24,
  parameter int IDX_W = 10,
  parameter int MAG_W = 15,
  parameter int AMP_W = 16,
  parameter int OUT_W = 16,
  parameter int N_OUT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  bsg_pkg::bsgCtrl_t       ctrl,
  input  logic [ACC_W-1:0]        tuningWord,
  input  logic [AMP_W-1:0]        ampScale,
  output logic signed [OUT_W-1:0] samples [N_OUT],
  output logic [IDX_W-1:0]        phaseIdx,
  output logic                    sampleValid
);
  localparam int PROD_W = MAG_W + AMP_W + 2;
  localparam logic signed [PROD_W-1:0] ROUND_HALF = PROD_W'(1) <<< (AMP_W - 1);

  logic [ACC_W-1:0]        acc;
  logic [IDX_W-1:0]        curIdx;
  logic signed [OUT_W-1:0] sampleNext [N_OUT];

  assign curIdx = acc[ACC_W-1 -: IDX_W];

  for (genvar p = 0; p < N_OUT; p++) begin : gPhase
    localparam logic [IDX_W-1:0] OFF = IDX_W'(bsg_pkg::phaseOffset(p, IDX_W));
    logic [IDX_W-1:0]         lookIdx;
    logic signed [MAG_W:0]    value;
    logic signed [PROD_W-1:0] prod;

    assign lookIdx = curIdx + OFF;

    bsg_lookup #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_lookup (
      .idx  (lookIdx),
      .value(value)
    );

    always_comb begin
      prod          = PROD_W'(value) * $signed(PROD_W'({1'b0, ampScale}));
      sampleNext[p] = OUT_W'((prod + ROUND_HALF) >>> AMP_W);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      phaseIdx    <= '0;
      sampleValid <= 1'b0;
      for (int p = 0; p < N_OUT; p++) samples[p] <= '0;
    end else if (ctrl.clear) begin
      phaseIdx    <= '0;
      sampleValid <= 1'b0;
      for (int p = 0; p < N_OUT; p++) samples[p] <= '0;
    end else begin
      sampleValid <= ctrl.tick;
      if (ctrl.tick) begin
        acc      <= acc + tuningWord;
        phaseIdx <= curIdx;
        for (int p = 0; p < N_OUT; p++) samples[p] <= sampleNext[p];
      end
    end
  end
endmodule

// File: rtl/bist_sine_gen.sv
module bist_sine_gen #(
  parameter int ACC_W      = 24,
  parameter int IDX_W      = 10,
  parameter int MAG_W      = 15,
  parameter int AMP_W      = 16,
  parameter int OUT_W      = 16,
  parameter int SAMPLE_DIV = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic [ACC_W-1:0]        tuningWord,
  input  logic [AMP_W-1:0]        ampScale,
  output logic signed [OUT_W-1:0] sample0,
  output logic signed [OUT_W-1:0] sample90,
  output logic signed [OUT_W-1:0] sample120,
  output logic signed [OUT_W-1:0] sample240,
  output logic                    sampleValid,
  output logic [IDX_W-1:0]        phaseIdx
);
  bsg_pkg::bsgCtrl_t       ctrl;
  logic signed [OUT_W-1:0] samples [4];

  bsg_ctrl #(.SAMPLE_DIV(SAMPLE_DIV)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .enable(enable),
    .ctrl  (ctrl)
  );

  bsg_datapath #(
    .ACC_W(ACC_W), .IDX_W(IDX_W), .MAG_W(MAG_W),
    .AMP_W(AMP_W), .OUT_W(OUT_W), .N_OUT(4)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .tuningWord (tuningWord),
    .ampScale   (ampScale),
    .samples    (samples),
    .phaseIdx   (phaseIdx),
    .sampleValid(sampleValid)
  );

  assign sample0   = samples[0];
  assign sample90  = samples[1];
  assign sample120 = samples[2];
  assign sample240 = samples[3];
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
  parameter int IDX_W      = 10,
  parameter int AMP_W      = 16,
  parameter int OUT_W      = 16,
  parameter int SAMPLE_DIV = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic [AMP_W-1:0]        ampScale,
  input logic signed [OUT_W-1:0] sample0,
  input logic signed [OUT_W-1:0] sample90,
  input logic signed [OUT_W-1:0] sample120,
  input logic signed [OUT_W-1:0] sample240,
  input logic                    sampleValid,
  input logic [IDX_W-1:0]        phaseIdx
);
  function automatic int absv(logic signed [OUT_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phaseIdx == '0) && !sampleValid && (sample0 == 0)); // R1

  AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sampleValid && sample0 == 0 && sample90 == 0 &&
                sample120 == 0 && sample240 == 0); // R8

  AST_AMP_BOUND: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> absv(sample0)   <= int'($past(ampScale)) / 2 + 1 &&
                    absv(sample90)  <= int'($past(ampScale)) / 2 + 1 &&
                    absv(sample120) <= int'($past(ampScale)) / 2 + 1 &&
                    absv(sample240) <= int'($past(ampScale)) / 2 + 1); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && enable && !sampleValid && !$past(rst)) |->
      $stable(sample0) && $stable(sample90) && $stable(phaseIdx)); // R9

  if (SAMPLE_DIV > 1) begin : gPulse
    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
      sampleValid |=> !sampleValid); // R2
  end
endmodule

bind bist_sine_gen bsg_checker #(
  .IDX_W(IDX_W), .AMP_W(AMP_W), .OUT_W(OUT_W), .SAMPLE_DIV(SAMPLE_DIV)
) u_checker (
  .clk(clk), .rst(rst), .enable(enable), .ampScale(ampScale),
  .sample0(sample0), .sample90(sample90), .sample120(sample120),
  .sample240(sample240), .sampleValid(sampleValid), .phaseIdx(phaseIdx)
);

// File: tb/bist_sine_gen_bench.sv
`timescale 1ns/1ps
module bist_sine_gen_bench;
  localparam int DIV = 4;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [23:0] tuningWord = '0;
  logic [15:0] ampScale = '0;
  logic signed [15:0] sample0, sample90, sample120, sample240;
  logic        sampleValid;
  logic [9:0]  phaseIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] modelPhase = '0;

  always #2.5 clk = ~clk;

  bist_sine_gen #(.SAMPLE_DIV(DIV)) u_bist_sine_gen (
    .clk(clk), .rst(rst), .enable(enable), .tuningWord(tuningWord),
    .ampScale(ampScale), .sample0(sample0), .sample90(sample90),
    .sample120(sample120), .sample240(sample240),
    .sampleValid(sampleValid), .phaseIdx(phaseIdx)
  );

  task automatic chk(string tag, longint got, longint exp, int tol);
    longint d;
    checks++;
    d = (got > exp) ? got - exp : exp - got;
    if (d > tol) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint expSample(int j, int amp);
    real ang;
    longint m;
    ang = (2.0 * j + 1.0) * PI / 1024.0;
    m = longint'($floor(32767.0 * $sin(ang) + 0.5));
    return (m * amp + 32768) >>> 16;
  endfunction

  task automatic checkZeroOut(string tag);
    chk({tag, " valid"}, sampleValid, 0, 0);
    chk({tag, " s0"}, sample0, 0, 0);
    chk({tag, " s90"}, sample90, 0, 0);
    chk({tag, " s120"}, sample120, 0, 0);
    chk({tag, " s240"}, sample240, 0, 0);
  endtask

  // Wait for one strobe, called at a negedge just after the previous one
  task automatic nextStrobe();
    int gap = 0;
    int idx;
    bit got = 0;
    while (!got && gap < 64) begin
      @(negedge clk);
      gap++;
      if (sampleValid) got = 1;
    end
    chk("R2 strobe spacing", gap, DIV, 0);
    if (got) begin
      idx = int'(modelPhase[23:14]);
      chk("R3 phaseIdx", phaseIdx, idx, 0);
      chk("R4 sample0", sample0, expSample(idx, int'(ampScale)), 1);
      chk("R5 sample90", sample90, expSample((idx + 256) % 1024, int'(ampScale)), 1);
      chk("R6 sample120", sample120, expSample((idx + 341) % 1024, int'(ampScale)), 1);
      chk("R6 sample240", sample240, expSample((idx + 683) % 1024, int'(ampScale)), 1);
      if (ampScale == 0) begin
        chk("R7 zero amp s0", sample0, 0, 0);
        chk("R7 zero amp s90", sample90, 0, 0);
        chk("R7 zero amp s120", sample120, 0, 0);
        chk("R7 zero amp s240", sample240, 0, 0);
      end
      modelPhase = modelPhase + tuningWord;
    end
  endtask

  task automatic pauseAndSet(logic [23:0] tw, logic [15:0] amp);
    enable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      checkZeroOut("R8 disabled");
    end
    tuningWord = tw;
    ampScale   = amp;
    enable     = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checkZeroOut("R1 reset");
      chk("R1 reset phaseIdx", phaseIdx, 0, 0);
    end
    rst = 1'b0;
    tuningWord = 24'h004000;
    ampScale   = 16'hFFFF;
    enable     = 1'b1;
    modelPhase = '0;
    // full index sweep plus wrap back to index 0
    for (int s = 0; s < 1025; s++) nextStrobe();
    chk("R3 wrap to zero", phaseIdx, 0, 0);

    // pause mid-run; phase must continue afterwards
    for (int s = 0; s < 37; s++) nextStrobe();
    pauseAndSet(24'h012345, 16'h5A5A);
    for (int s = 0; s < 300; s++) nextStrobe();

    pauseAndSet(24'h00A000, 16'h0000);
    for (int s = 0; s < 16; s++) nextStrobe();

    pauseAndSet(24'h3FFFFF, 16'h0003);
    for (int s = 0; s < 64; s++) nextStrobe();

    pauseAndSet(24'hF0F0F1, 16'h8001);
    for (int s = 0; s < 64; s++) nextStrobe();

    // reset while running: phase restarts at zero
    rst = 1'b1;
    @(negedge clk);
    checkZeroOut("R1 mid reset");
    rst = 1'b0;
    modelPhase = '0;
    for (int s = 0; s < 8; s++) nextStrobe();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule